// File: doc/BRIEF.md
# OSD Register Write Parser

This block turns the byte stream of a receive-only serial-bus slave into write commands for an on-screen-display engine. The bit-level front end hands over each received payload byte together with a flag saying whether the current transfer was addressed to this device (slave address 0x7A on the write side, 0x3D as a 7-bit address). It also reports START and STOP conditions. The parser classifies every byte as a row address, a column address or a data byte. For each data byte it issues a one-cycle write strobe carrying a target memory, a row, a column and the byte itself.

Three addressing styles can be mixed in one transfer. In the first, each data byte is preceded by a row and a column. In the second, a row stays in force and several column/data pairs follow it. In the third, a single row and column open a burst. In a burst every later byte is data and the column steps forward after each write, wrapping into the next row. Once a burst has begun, no further address bytes are recognised until the transfer ends.

Top module: `osd_wr_parser`

## Requirements
- R1: After reset the parser waits for a row address and `wr_stb` is low.
- R2: A byte with bit 7 = 1 in the idle or column-expected state is a row address. Bit 6 = 1 selects RAM font memory (`wr_tgt` = 2, row = bits 2:0). Bits 6:5 = 01 selects attribute/control memory (`wr_tgt` = 1). Bits 6:5 = 00 selects display code memory (`wr_tgt` = 0). For targets 1 and 0 the row is bits 3:0.
- R3: A byte with bit 7 = 0 that follows a row address is a column address. For code/attribute the column is bits 4:0, and for RAM font it is bits 5:0. Bit 6 = 1 opens a burst, and bit 6 = 0 selects a single write.
- R4: In a single write, exactly one byte (of any value) follows the column. That byte produces a strobe one cycle after the byte is accepted. The parser then accepts either a new row byte or a new column byte under the same row.
- R5: In a burst, every byte is data, including those with bit 7 = 1. Each byte is written, and the column then advances by one.
- R6: In a burst, a write at or beyond the last column of the target (31 for code/attribute, 35 for RAM font) is followed by column 0 and the next row. The row wraps modulo 16 for code/attribute and modulo 8 for RAM font.
- R7: START or STOP returns the parser to the idle state. A byte presented in the same cycle is dropped and gives no strobe.
- R8: A byte presented while `addr_match` is low gives no strobe and leaves the parser state (including the burst position) unchanged.
- R9: A byte with bit 7 = 0 arriving in the idle state is discarded without a strobe, and the parser keeps waiting for a row.
- R10: `wr_stb` is a single-cycle pulse per accepted data byte, and `wr_tgt` is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | One-cycle pulse: a received byte is on `byte_data` |
| byte_data | input | 8 | Received payload byte |
| addr_match | input | 1 | Current transfer is addressed to this device |
| start_evt | input | 1 | START condition seen on the bus |
| stop_evt | input | 1 | STOP condition seen on the bus |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_tgt | output | 2 | 0 display code, 1 attribute/control, 2 RAM font |
| wr_row | output | ROW_W (4) | Row of the write |
| wr_col | output | COL_W (6) | Column of the write |
| wr_data | output | 8 | Byte to write |

## Verification
The bench uses the default parameters: a 4-bit row, a 3-bit font row, last columns 31 and 35, and a registered output stage. These settings put every wrap point within a few bytes of a burst start: code row 15 to 0, font row 7 to 0, and columns 31 and 35 to 0. Directed transfers cover each addressing style, bursts whose data looks like address bytes, and control events landing on a byte. Seeded random streams then mix matched and unmatched bytes, START and STOP at arbitrary points, and all byte values.

// File: rtl/osd_wr_pkg.sv
package osd_wr_pkg;

   typedef enum logic [1:0] {
      TGT_CODE = 2'd0,
      TGT_ATTR = 2'd1,
      TGT_FONT = 2'd2
   } osd_tgt_e;

   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_COL   = 2'd1,
      PS_DATA  = 2'd2,
      PS_BURST = 2'd3
   } osd_pstate_e;

endpackage

// File: rtl/osd_byte_decode.sv
module osd_byte_decode
   import osd_wr_pkg::*;
#(
   parameter int ROW_W      = 4,
   parameter int FONT_ROW_W = 3,
   parameter int COL_W      = 6,
   parameter int CODE_COL_W = 5,
   parameter int FONT_COL_W = 6
) (
   input  logic [7:0]       byte_i,
   input  osd_tgt_e         cur_tgt,
   output logic             is_row,
   output osd_tgt_e         row_tgt,
   output logic [ROW_W-1:0] row_num,
   output logic             col_burst,
   output logic [COL_W-1:0] col_num
);

   always_comb begin
      is_row    = byte_i[7];
      col_burst = byte_i[6];
      if (byte_i[6])
         row_tgt = TGT_FONT;
      else if (byte_i[5])
         row_tgt = TGT_ATTR;
      else
         row_tgt = TGT_CODE;

      row_num = '0;
      if (row_tgt == TGT_FONT)
         row_num[FONT_ROW_W-1:0] = byte_i[FONT_ROW_W-1:0];
      else
         row_num = byte_i[ROW_W-1:0];

      col_num = '0;
      if (cur_tgt == TGT_FONT)
         col_num[FONT_COL_W-1:0] = byte_i[FONT_COL_W-1:0];
      else
         col_num[CODE_COL_W-1:0] = byte_i[CODE_COL_W-1:0];
   end

endmodule

// File: rtl/osd_burst_step.sv
module osd_burst_step
   import osd_wr_pkg::*;
#(
   parameter int ROW_W         = 4,
   parameter int FONT_ROW_W    = 3,
   parameter int COL_W         = 6,
   parameter int CODE_LAST_COL = 31,
   parameter int FONT_LAST_COL = 35
) (
   input  osd_tgt_e         tgt_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   output logic [ROW_W-1:0] row_o,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] last_col;
   logic             at_end;

   assign last_col = (tgt_i == TGT_FONT) ? COL_W'(FONT_LAST_COL) : COL_W'(CODE_LAST_COL);
   assign at_end   = (col_i >= last_col);

   always_comb begin
      row_o = row_i;
      col_o = col_i + COL_W'(1);
      if (at_end) begin
         col_o = '0;
         if (tgt_i == TGT_FONT) begin
            row_o = '0;
            row_o[FONT_ROW_W-1:0] = row_i[FONT_ROW_W-1:0] + FONT_ROW_W'(1);
         end else begin
            row_o = row_i + ROW_W'(1);
         end
      end
   end

endmodule

// File: rtl/osd_wr_parser.sv
module osd_wr_parser
   import osd_wr_pkg::*;
#(
   parameter int ROW_W         = 4,
   parameter int FONT_ROW_W    = 3,
   parameter int CODE_LAST_COL = 31,
   parameter int FONT_LAST_COL = 35,
   parameter bit REG_OUT       = 1'b1,
   localparam int CODE_COL_W   = $clog2(CODE_LAST_COL + 1),
   localparam int FONT_COL_W   = $clog2(FONT_LAST_COL + 1),
   localparam int COL_W        = (CODE_COL_W > FONT_COL_W) ? CODE_COL_W : FONT_COL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic [7:0]       byte_data,
   input  logic             addr_match,
   input  logic             start_evt,
   input  logic             stop_evt,
   output logic             wr_stb,
   output logic [1:0]       wr_tgt,
   output logic [ROW_W-1:0] wr_row,
   output logic [COL_W-1:0] wr_col,
   output logic [7:0]       wr_data
);

   // Parameter sanity: address fields must sit below the selector bits.
   if (ROW_W < 1 || ROW_W > 5) begin : g_bad_row_w
      $error("ROW_W must lie in 1..5");
   end
   if (FONT_ROW_W < 1 || FONT_ROW_W > ROW_W) begin : g_bad_font_row_w
      $error("FONT_ROW_W must lie in 1..ROW_W");
   end
   if (CODE_COL_W < 1 || CODE_COL_W > 5) begin : g_bad_code_col
      $error("CODE_LAST_COL must fit in byte bits 4:0");
   end
   if (FONT_COL_W < 1 || FONT_COL_W > 6) begin : g_bad_font_col
      $error("FONT_LAST_COL must fit in byte bits 5:0");
   end

   osd_pstate_e      st_q,  st_d;
   osd_tgt_e         tgt_q, tgt_d;
   logic [ROW_W-1:0] row_q, row_d;
   logic [COL_W-1:0] col_q, col_d;
   logic             req;

   logic             dec_is_row;
   osd_tgt_e         dec_tgt;
   logic [ROW_W-1:0] dec_row;
   logic             dec_burst;
   logic [COL_W-1:0] dec_col;
   logic [ROW_W-1:0] stp_row;
   logic [COL_W-1:0] stp_col;
   logic             take;

   osd_byte_decode #(
      .ROW_W      (ROW_W),
      .FONT_ROW_W (FONT_ROW_W),
      .COL_W      (COL_W),
      .CODE_COL_W (CODE_COL_W),
      .FONT_COL_W (FONT_COL_W)
   ) u_dec (
      .byte_i    (byte_data),
      .cur_tgt   (tgt_q),
      .is_row    (dec_is_row),
      .row_tgt   (dec_tgt),
      .row_num   (dec_row),
      .col_burst (dec_burst),
      .col_num   (dec_col)
   );

   osd_burst_step #(
      .ROW_W         (ROW_W),
      .FONT_ROW_W    (FONT_ROW_W),
      .COL_W         (COL_W),
      .CODE_LAST_COL (CODE_LAST_COL),
      .FONT_LAST_COL (FONT_LAST_COL)
   ) u_step (
      .tgt_i (tgt_q),
      .row_i (row_q),
      .col_i (col_q),
      .row_o (stp_row),
      .col_o (stp_col)
   );

   assign take = byte_vld && addr_match;

   always_comb begin
      st_d  = st_q;
      tgt_d = tgt_q;
      row_d = row_q;
      col_d = col_q;
      req   = 1'b0;
      if (start_evt || stop_evt) begin
         st_d = PS_IDLE;
      end else if (take) begin
         unique case (st_q)
            PS_IDLE: begin
               if (dec_is_row) begin
                  tgt_d = dec_tgt;
                  row_d = dec_row;
                  st_d  = PS_COL;
               end
            end
            PS_COL: begin
               if (dec_is_row) begin
                  tgt_d = dec_tgt;
                  row_d = dec_row;
               end else begin
                  col_d = dec_col;
                  st_d  = dec_burst ? PS_BURST : PS_DATA;
               end
            end
            PS_DATA: begin
               req  = 1'b1;
               st_d = PS_COL;
            end
            PS_BURST: begin
               req   = 1'b1;
               row_d = stp_row;
               col_d = stp_col;
            end
            default: st_d = PS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= PS_IDLE;
         tgt_q <= TGT_CODE;
         row_q <= '0;
         col_q <= '0;
      end else begin
         st_q  <= st_d;
         tgt_q <= tgt_d;
         row_q <= row_d;
         col_q <= col_d;
      end
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_tgt  <= 2'd0;
            wr_row  <= '0;
            wr_col  <= '0;
            wr_data <= '0;
         end else begin
            wr_stb <= req;
            if (req) begin
               wr_tgt  <= tgt_q;
               wr_row  <= row_q;
               wr_col  <= col_q;
               wr_data <= byte_data;
            end
         end
      end
   end else begin : g_comb_out
      assign wr_stb  = req;
      assign wr_tgt  = tgt_q;
      assign wr_row  = row_q;
      assign wr_col  = col_q;
      assign wr_data = byte_data;
   end

endmodule

// File: rtl/osd_wr_parser_chk.sv
module osd_wr_parser_chk #(
   parameter int ROW_W      = 4,
   parameter int FONT_ROW_W = 3,
   parameter bit REG_OUT    = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_vld,
   input logic             addr_match,
   input logic             start_evt,
   input logic             stop_evt,
   input logic             wr_stb,
   input logic [1:0]       wr_tgt,
   input logic [ROW_W-1:0] wr_row
);

   AST_TGT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_tgt != 2'd3)); // R10

   AST_FONT_ROW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_tgt == 2'd2) |-> ((wr_row >> FONT_ROW_W) == '0)); // R2

   if (REG_OUT) begin : g_reg_chk
      AST_CTRL_DROPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
         (start_evt || stop_evt) |=> !wr_stb); // R7

      AST_UNMATCHED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_vld && !addr_match) |=> !wr_stb); // R8

      AST_STB_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         wr_stb |-> $past(byte_vld && addr_match)); // R4
   end

endmodule

bind osd_wr_parser osd_wr_parser_chk #(
   .ROW_W      (ROW_W),
   .FONT_ROW_W (FONT_ROW_W),
   .REG_OUT    (REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_vld   (byte_vld),
   .addr_match (addr_match),
   .start_evt  (start_evt),
   .stop_evt   (stop_evt),
   .wr_stb     (wr_stb),
   .wr_tgt     (wr_tgt),
   .wr_row     (wr_row)
);

// File: tb/test_osd_wr_parser.sv
module test_osd_wr_parser;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic       addr_match = 1'b0;
   logic       start_evt = 1'b0;
   logic       stop_evt = 1'b0;
   logic       wr_stb;
   logic [1:0] wr_tgt;
   logic [3:0] wr_row;
   logic [5:0] wr_col;
   logic [7:0] wr_data;

   int vectors = 0;
   int errors  = 0;

   // bench model of the requirements
   int mst  = 0;   // 0 idle, 1 column expected, 2 single data, 3 burst
   int mtgt = 0;
   int mrow = 0;
   int mcol = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   osd_wr_parser i_osd_wr_parser (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_vld   (byte_vld),
      .byte_data  (byte_data),
      .addr_match (addr_match),
      .start_evt  (start_evt),
      .stop_evt   (stop_evt),
      .wr_stb     (wr_stb),
      .wr_tgt     (wr_tgt),
      .wr_row     (wr_row),
      .wr_col     (wr_col),
      .wr_data    (wr_data)
   );

   function automatic int tgt_of(input logic [7:0] b);
      if (b[6]) return 2;
      if (b[5]) return 1;
      return 0;
   endfunction

   function automatic int last_col_of(input int t);
      return (t == 2) ? 35 : 31;
   endfunction

   task automatic check(input string tag, input logic es, input int et, input int er,
                        input int ec, input int ed);
      vectors++;
      if (wr_stb !== es || (es && (wr_tgt != 2'(et) || wr_row != 4'(er) ||
                                   wr_col != 6'(ec) || wr_data != 8'(ed)))) begin
         errors++;
         $display("FAIL %s: got stb=%0b tgt=%0d row=%0d col=%0d data=%02h, expected stb=%0b tgt=%0d row=%0d col=%0d data=%02h",
                  tag, wr_stb, wr_tgt, wr_row, wr_col, wr_data, es, et, er, ec, ed);
      end
   endtask

   // Present one byte, predict from the model, check the cycle after.
   task automatic push(input logic [7:0] b, input logic m, input string tag);
      logic es = 1'b0;
      int   et = 0, er = 0, ec = 0;
      if (m) begin
         case (mst)
            0: if (b[7]) begin
                  mtgt = tgt_of(b);
                  mrow = (mtgt == 2) ? int'(b[2:0]) : int'(b[3:0]);
                  mst  = 1;
               end
            1: if (b[7]) begin
                  mtgt = tgt_of(b);
                  mrow = (mtgt == 2) ? int'(b[2:0]) : int'(b[3:0]);
               end else begin
                  mcol = (mtgt == 2) ? int'(b[5:0]) : int'(b[4:0]);
                  mst  = b[6] ? 3 : 2;
               end
            2: begin
                  es = 1'b1; et = mtgt; er = mrow; ec = mcol;
                  mst = 1;
               end
            default: begin
                  es = 1'b1; et = mtgt; er = mrow; ec = mcol;
                  if (mcol >= last_col_of(mtgt)) begin
                     mcol = 0;
                     mrow = (mtgt == 2) ? ((mrow + 1) % 8) : ((mrow + 1) % 16);
                  end else begin
                     mcol = mcol + 1;
                  end
               end
         endcase
      end
      @(negedge clk);
      byte_vld = 1'b1; byte_data = b; addr_match = m;
      @(negedge clk);
      byte_vld = 1'b0; addr_match = 1'b0;
      check(tag, es, et, er, ec, int'(b));
   endtask

   // START (is_start=1) or STOP, optionally with a byte in the same cycle.
   task automatic ctrl(input logic is_start, input logic with_byte, input logic [7:0] b,
                       input string tag);
      mst = 0;
      @(negedge clk);
      start_evt = is_start; stop_evt = !is_start;
      byte_vld = with_byte; byte_data = b; addr_match = 1'b1;
      @(negedge clk);
      start_evt = 1'b0; stop_evt = 1'b0; byte_vld = 1'b0; addr_match = 1'b0;
      check(tag, 1'b0, 0, 0, 0, 0);
   endtask

   task automatic quiet(input string tag);
      @(negedge clk);
      check(tag, 1'b0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h0D5C_2B17));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      quiet("R1 reset state");

      // R2 / R4: single write to code memory
      ctrl(1'b1, 1'b0, 8'h00, "R7 start");
      push(8'h83, 1'b1, "R2 code row");
      push(8'h05, 1'b1, "R3 single column");
      push(8'hAB, 1'b1, "R4 single write code");
      quiet("R10 strobe is one cycle");
      // R2 attribute target, R4 same-row column follow-up
      push(8'hA7, 1'b1, "R2 attr row");
      push(8'h1F, 1'b1, "R3 attr column 31");
      push(8'h42, 1'b1, "R2 attr write");
      push(8'h02, 1'b1, "R4 same-row column");
      push(8'h99, 1'b1, "R4 same-row write");
      // R2 font row ignores bit 3; R3 font column uses bits 5:0
      push(8'hCD, 1'b1, "R2 font row");
      push(8'h23, 1'b1, "R3 font column 35");
      push(8'h3C, 1'b1, "R3 font write");

      // R5 burst: address-looking data is written; R6 column wrap
      ctrl(1'b0, 1'b0, 8'h00, "R7 stop");
      ctrl(1'b1, 1'b0, 8'h00, "R7 start");
      push(8'h81, 1'b1, "R2 code row 1");
      push(8'h5E, 1'b1, "R3 burst column 30");
      push(8'h11, 1'b1, "R5 burst first");
      push(8'h90, 1'b1, "R5 burst data with bit7");
      push(8'h22, 1'b1, "R6 code column wrap");
      push(8'h55, 1'b0, "R8 unmatched in burst");
      push(8'h33, 1'b1, "R8 burst resumes in place");

      // R6 font burst wrap, font row 7 -> 0
      ctrl(1'b1, 1'b0, 8'h00, "R7 start");
      push(8'hC7, 1'b1, "R2 font row 7");
      push(8'h62, 1'b1, "R3 font burst column 34");
      push(8'h01, 1'b1, "R6 font col 34");
      push(8'h02, 1'b1, "R6 font col 35");
      push(8'h03, 1'b1, "R6 font row wrap");

      // R6 code row 15 -> 0
      ctrl(1'b1, 1'b0, 8'h00, "R7 start");
      push(8'h8F, 1'b1, "R2 code row 15");
      push(8'h5F, 1'b1, "R3 burst column 31");
      push(8'hE1, 1'b1, "R6 last cell");
      push(8'hE2, 1'b1, "R6 code row wrap");

      // R7 start with a byte in the same cycle; R9 stray column in idle
      ctrl(1'b1, 1'b1, 8'h44, "R7 byte with start dropped");
      push(8'h12, 1'b1, "R9 column byte in idle");
      push(8'h34, 1'b1, "R9 still idle");
      push(8'h80, 1'b1, "R9 row after discard");
      push(8'h01, 1'b1, "R9 column");
      push(8'h77, 1'b1, "R9 write after discard");
      ctrl(1'b0, 1'b1, 8'h66, "R7 byte with stop dropped");
      push(8'h05, 1'b1, "R7 idle after stop");

      // R8 unmatched bytes do not move the parser
      push(8'hA2, 1'b0, "R8 unmatched row");
      push(8'h03, 1'b1, "R8 still idle");
      push(8'hA2, 1'b1, "R8 matched row");
      push(8'h44, 1'b0, "R8 unmatched column");
      push(8'h04, 1'b1, "R8 column");
      push(8'h5A, 1'b1, "R8 write");

      // seeded random mix
      for (int i = 0; i < 4000; i++) begin
         int r = int'($urandom % 100);
         if (r < 2)
            ctrl(1'b1, ($urandom % 2) == 0, 8'($urandom), "R7 random start");
         else if (r < 4)
            ctrl(1'b0, ($urandom % 2) == 0, 8'($urandom), "R7 random stop");
         else
            push(8'($urandom), ($urandom % 12) != 0, "RAND stream");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule